// File: doc/BRIEF.md
# Overlay Alpha Blending Datapath

This block merges one overlay pixel (the source) with the pixel of the layer below it (the destination) and produces one blended pixel. Both pixels are 32-bit ARGB words with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. The three colour channels and the alpha channel are blended separately. Each is computed as source times a source factor plus destination times a destination factor. Every factor is an 8-bit fixed-point fraction in which 255 stands for 1.0. A coded selector picks each factor. The choices are constants, two programmable alpha operands, products of an operand with the source or destination alpha, and one-minus forms.

An optional colour key compares a 24-bit RGB value against the pixel stream. A key-position input chooses where the compare happens. It can test the overlay pixel before the blend, or test the blended result after it. On a hit, the pixel that was tested is replaced by the destination pixel. All configuration is sampled together with the pixel, so it may change on every valid cycle. Results appear after a fixed two-cycle pipeline, with a valid strobe alongside.

Top module: `ovl_blend_top`

## Requirements
- R1: A pixel presented with `inValid` high at clock edge k produces `outValid` high for exactly one cycle after edge k+2. `outValid` is never high without a matching input.
- R2: Each colour channel is min(255, floor((S*Fs + D*Fd)/255)), where Fs and Fd are the colour factors. The result saturates at 255.
- R3: The alpha channel (bits 31:24) uses the same formula with the alpha factors. `srcAlphaSel` chooses the source factor and `dstAlphaSel` the destination factor.
- R4: The source colour factor code `srcColorSel` selects: 0 gives 255, 1 gives 0, 2 gives A0, 3 gives N(A0,Da), 4 gives N(A0,Sa), 5 gives 255-N(A0,Da). Codes 6 and 7 behave as code 0.
- R5: The destination colour factor code `dstColorSel` selects: 0 gives 0, 1 gives 255, 2 gives A0, 3 gives A1, 4 gives N(A0,Da), 5 gives 255-N(A0,Da), 6 gives 255-N(A0,Sa), 7 gives 255-(255-A0).
- R6: The source alpha factor code `srcAlphaSel` selects: 0 gives 0, 1 gives 255, 2 gives A0, 3 gives A1.
- R7: The destination alpha factor code `dstAlphaSel` selects: 0 gives 0, 1 gives 255, 2 gives 255-N(A0,Sa), 3 gives A1.
- R8: N(x,y) = floor((x*y + 127)/255). Sa is the alpha of the effective source pixel and Da is the alpha of the destination pixel.
- R9: If `keyEnable`=1, `keyAfterBlend`=0 and the source RGB equals `keyColor`, the whole destination pixel replaces the source pixel before the factors are chosen. Sa is then the destination alpha.
- R10: If `keyEnable`=1, `keyAfterBlend`=1 and the blended RGB equals `keyColor`, the output is the destination pixel. A source RGB match has no effect in this mode.
- R11: With `keyEnable`=0, the key inputs have no effect on the result.
- R12: After reset `outPix` is 0 and `outValid` is 0. `outPix` holds its last value while `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel and configuration are valid |
| srcPix | input | 32 | Overlay (source) ARGB pixel |
| dstPix | input | 32 | Underlying (destination) ARGB pixel |
| alphaOp0 | input | 8 | Programmable alpha operand A0 |
| alphaOp1 | input | 8 | Programmable alpha operand A1 |
| srcColorSel | input | 3 | Source colour factor code |
| dstColorSel | input | 3 | Destination colour factor code |
| srcAlphaSel | input | 2 | Source alpha factor code |
| dstAlphaSel | input | 2 | Destination alpha factor code |
| keyEnable | input | 1 | Colour key enable |
| keyAfterBlend | input | 1 | Key position: 0 tests source before blend, 1 tests result after blend |
| keyColor | input | 24 | RGB key compare value |
| outValid | output | 1 | Blended pixel valid |
| outPix | output | 32 | Blended ARGB pixel |

## Verification
The bench walks every factor code of all four selectors, including the two reserved source colour codes. A design that decoded them as zero would darken the overlay to nothing. It drives full-scale pixels with both factors at 1.0, where missing saturation wraps the channel to a small value. It also drives products where rounding by 127 changes the last bit.

Key tests use pixels whose RGB matches the key in the wrong position, or with the key disabled. A design that ignored the position bit would substitute the destination when it should not. In pre-blend keying the source alpha must come from the replaced pixel. A design that took the original overlay alpha there would produce a different factor.

Gaps between valid inputs catch an output that drifts while idle. Back-to-back traffic with per-cycle configuration changes catches configuration that is not carried along with its pixel.

// File: rtl/blend_pkg.sv
`timescale 1ns/1ps
package blend_pkg;
  localparam int CHAN_W   = 8;
  localparam int NUM_CHAN = 4;
  localparam int PIX_W    = CHAN_W * NUM_CHAN;
  localparam int RGB_W    = CHAN_W * (NUM_CHAN - 1);
  localparam logic [CHAN_W-1:0] FULL = {CHAN_W{1'b1}};

  typedef logic [CHAN_W-1:0] chan_t;

  typedef struct packed {
    logic s1Load;
    logic preHit;
    logic s2Load;
    logic postEn;
  } blend_strb_t;

  function automatic chan_t mulNorm(chan_t a, chan_t b);
    logic [2*CHAN_W-1:0] prod;
    prod = (2*CHAN_W)'(a) * (2*CHAN_W)'(b) + (2*CHAN_W)'(FULL >> 1);
    return chan_t'(prod / (2*CHAN_W)'(FULL));
  endfunction

  function automatic chan_t srcColorFac(logic [2:0] code, chan_t a0, chan_t sa, chan_t da);
    case (code)
      3'd1:    return '0;
      3'd2:    return a0;
      3'd3:    return mulNorm(a0, da);
      3'd4:    return mulNorm(a0, sa);
      3'd5:    return FULL - mulNorm(a0, da);
      default: return FULL;
    endcase
  endfunction

  function automatic chan_t dstColorFac(logic [2:0] code, chan_t a0, chan_t a1, chan_t sa, chan_t da);
    case (code)
      3'd0:    return '0;
      3'd1:    return FULL;
      3'd2:    return a0;
      3'd3:    return a1;
      3'd4:    return mulNorm(a0, da);
      3'd5:    return FULL - mulNorm(a0, da);
      3'd6:    return FULL - mulNorm(a0, sa);
      default: return FULL - (FULL - a0);
    endcase
  endfunction

  function automatic chan_t srcAlphaFac(logic [1:0] code, chan_t a0, chan_t a1);
    case (code)
      2'd0:    return '0;
      2'd1:    return FULL;
      2'd2:    return a0;
      default: return a1;
    endcase
  endfunction

  function automatic chan_t dstAlphaFac(logic [1:0] code, chan_t a0, chan_t a1, chan_t sa);
    case (code)
      2'd0:    return '0;
      2'd1:    return FULL;
      2'd2:    return FULL - mulNorm(a0, sa);
      default: return a1;
    endcase
  endfunction
endpackage

// File: rtl/blend_lane.sv
`timescale 1ns/1ps
module blend_lane
  import blend_pkg::*;
(
  input  chan_t srcVal,
  input  chan_t dstVal,
  input  chan_t srcFac,
  input  chan_t dstFac,
  output chan_t laneOut
);
  localparam int SUM_W = 2 * CHAN_W + 1;
  localparam int QUO_W = CHAN_W + 1;

  logic [SUM_W-1:0] sumVal;
  logic [QUO_W-1:0] quoVal;

  always_comb begin
    sumVal = SUM_W'(srcVal) * SUM_W'(srcFac) + SUM_W'(dstVal) * SUM_W'(dstFac);
    quoVal = QUO_W'(sumVal / SUM_W'(FULL));
    laneOut = quoVal[CHAN_W] ? FULL : quoVal[CHAN_W-1:0];
  end
endmodule

// File: rtl/blend_ctrl.sv
`timescale 1ns/1ps
module blend_ctrl
  import blend_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [RGB_W-1:0] srcRgb,
  input  logic             keyEnable,
  input  logic             keyAfterBlend,
  input  logic [RGB_W-1:0] keyColor,
  output blend_strb_t      strb,
  output logic             outValid
);
  logic s1Valid;
  logic postEnReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      outValid  <= 1'b0;
      postEnReg <= 1'b0;
    end else begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
      if (inValid) postEnReg <= keyEnable && keyAfterBlend;
    end
  end

  always_comb begin
    strb.s1Load = inValid;
    strb.preHit = inValid && keyEnable && !keyAfterBlend && (srcRgb == keyColor);
    strb.s2Load = s1Valid;
    strb.postEn = postEnReg;
  end

  // R1
  lat_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> s1Valid);
  // R1
  lat_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> outValid);
  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |=> !outValid);
endmodule

// File: rtl/blend_dp.sv
`timescale 1ns/1ps
module blend_dp
  import blend_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  blend_strb_t      strb,
  input  logic [PIX_W-1:0] srcPix,
  input  logic [PIX_W-1:0] dstPix,
  input  chan_t            alphaOp0,
  input  chan_t            alphaOp1,
  input  logic [2:0]       srcColorSel,
  input  logic [2:0]       dstColorSel,
  input  logic [1:0]       srcAlphaSel,
  input  logic [1:0]       dstAlphaSel,
  input  logic [RGB_W-1:0] keyColor,
  output logic [PIX_W-1:0] outPix
);
  localparam int A_LSB = RGB_W;

  logic [PIX_W-1:0] effSrc;
  chan_t            srcA, dstA;
  chan_t            facSc, facDc, facSa, facDa;

  logic [PIX_W-1:0] s1Src, s1Dst;
  chan_t            s1FacSc, s1FacDc, s1FacSa, s1FacDa;
  logic [RGB_W-1:0] s1Key;

  logic [PIX_W-1:0] blendPix;
  logic             postHit;

  always_comb begin
    effSrc = strb.preHit ? dstPix : srcPix;
    srcA   = effSrc[A_LSB +: CHAN_W];
    dstA   = dstPix[A_LSB +: CHAN_W];
    facSc  = srcColorFac(srcColorSel, alphaOp0, srcA, dstA);
    facDc  = dstColorFac(dstColorSel, alphaOp0, alphaOp1, srcA, dstA);
    facSa  = srcAlphaFac(srcAlphaSel, alphaOp0, alphaOp1);
    facDa  = dstAlphaFac(dstAlphaSel, alphaOp0, alphaOp1, srcA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Src   <= '0;
      s1Dst   <= '0;
      s1FacSc <= '0;
      s1FacDc <= '0;
      s1FacSa <= '0;
      s1FacDa <= '0;
      s1Key   <= '0;
    end else if (strb.s1Load) begin
      s1Src   <= effSrc;
      s1Dst   <= dstPix;
      s1FacSc <= facSc;
      s1FacDc <= facDc;
      s1FacSa <= facSa;
      s1FacDa <= facDa;
      s1Key   <= keyColor;
    end
  end

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_lane
    chan_t laneFs, laneFd;
    if (ch == NUM_CHAN - 1) begin : g_alpha
      assign laneFs = s1FacSa;
      assign laneFd = s1FacDa;
    end else begin : g_color
      assign laneFs = s1FacSc;
      assign laneFd = s1FacDc;
    end
    blend_lane i_lane (
      .srcVal (s1Src[ch*CHAN_W +: CHAN_W]),
      .dstVal (s1Dst[ch*CHAN_W +: CHAN_W]),
      .srcFac (laneFs),
      .dstFac (laneFd),
      .laneOut(blendPix[ch*CHAN_W +: CHAN_W])
    );
  end

  assign postHit = strb.postEn && (blendPix[RGB_W-1:0] == s1Key);

  always_ff @(posedge clk) begin
    if (!rstN) outPix <= '0;
    else if (strb.s2Load) outPix <= postHit ? s1Dst : blendPix;
  end

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.s2Load |=> $stable(outPix));
  // R2
  identity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && !postHit && s1FacSc == FULL && s1FacDc == '0)
      |=> outPix[RGB_W-1:0] == $past(s1Src[RGB_W-1:0]));
  // R10
  postkey_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && postHit) |=> outPix == $past(s1Dst));
  // R12
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.s1Load |=> $stable(s1Src) && $stable(s1FacSc));
endmodule

// File: rtl/ovl_blend_top.sv
`timescale 1ns/1ps
module ovl_blend_top
  import blend_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] srcPix,
  input  logic [31:0] dstPix,
  input  logic [7:0]  alphaOp0,
  input  logic [7:0]  alphaOp1,
  input  logic [2:0]  srcColorSel,
  input  logic [2:0]  dstColorSel,
  input  logic [1:0]  srcAlphaSel,
  input  logic [1:0]  dstAlphaSel,
  input  logic        keyEnable,
  input  logic        keyAfterBlend,
  input  logic [23:0] keyColor,
  output logic        outValid,
  output logic [31:0] outPix
);
  blend_strb_t strb;

  blend_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .srcRgb       (srcPix[RGB_W-1:0]),
    .keyEnable    (keyEnable),
    .keyAfterBlend(keyAfterBlend),
    .keyColor     (keyColor),
    .strb         (strb),
    .outValid     (outValid)
  );

  blend_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .srcPix     (srcPix),
    .dstPix     (dstPix),
    .alphaOp0   (alphaOp0),
    .alphaOp1   (alphaOp1),
    .srcColorSel(srcColorSel),
    .dstColorSel(dstColorSel),
    .srcAlphaSel(srcAlphaSel),
    .dstAlphaSel(dstAlphaSel),
    .keyColor   (keyColor),
    .outPix     (outPix)
  );
endmodule

// File: tb/test_ovl_blend_top.sv
`timescale 1ns/1ps
module test_ovl_blend_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcPix = '0, dstPix = '0;
  logic [7:0]  alphaOp0 = '0, alphaOp1 = '0;
  logic [2:0]  srcColorSel = '0, dstColorSel = '0;
  logic [1:0]  srcAlphaSel = '0, dstAlphaSel = '0;
  logic        keyEnable = 1'b0, keyAfterBlend = 1'b0;
  logic [23:0] keyColor = '0;
  logic        outValid;
  logic [31:0] outPix;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit seenOut = 0;
  logic [31:0] lastOut = '0;

  typedef struct { logic [31:0] pix; int due; string tag; } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ovl_blend_top i_ovl_blend_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcPix(srcPix), .dstPix(dstPix),
    .alphaOp0(alphaOp0), .alphaOp1(alphaOp1), .srcColorSel(srcColorSel),
    .dstColorSel(dstColorSel), .srcAlphaSel(srcAlphaSel), .dstAlphaSel(dstAlphaSel),
    .keyEnable(keyEnable), .keyAfterBlend(keyAfterBlend), .keyColor(keyColor),
    .outValid(outValid), .outPix(outPix)
  );

  function automatic int nrm(int x, int y);
    return (x * y + 127) / 255;
  endfunction

  function automatic int mixCh(int s, int d, int fs, int fd);
    int r;
    r = (s * fs + d * fd) / 255;
    return (r > 255) ? 255 : r;
  endfunction

  function automatic logic [31:0] model(logic [31:0] s, logic [31:0] d, int a0, int a1,
      int sc, int dc, int sal, int dal, bit ken, bit kpos, logic [23:0] key);
    logic [31:0] es, res;
    int sa, da, fsc, fdc, fsa, fda;
    es = (ken && !kpos && s[23:0] == key) ? d : s;   // R9
    sa = int'(es[31:24]);
    da = int'(d[31:24]);
    case (sc)                                          // R4
      1: fsc = 0;  2: fsc = a0;  3: fsc = nrm(a0, da);
      4: fsc = nrm(a0, sa);  5: fsc = 255 - nrm(a0, da);
      default: fsc = 255;
    endcase
    case (dc)                                          // R5
      0: fdc = 0;  1: fdc = 255;  2: fdc = a0;  3: fdc = a1;
      4: fdc = nrm(a0, da);  5: fdc = 255 - nrm(a0, da);
      6: fdc = 255 - nrm(a0, sa);  default: fdc = a0;
    endcase
    case (sal)                                         // R6
      0: fsa = 0;  1: fsa = 255;  2: fsa = a0;  default: fsa = a1;
    endcase
    case (dal)                                         // R7
      0: fda = 0;  1: fda = 255;  2: fda = 255 - nrm(a0, sa);  default: fda = a1;
    endcase
    res[31:24] = 8'(mixCh(sa, da, fsa, fda));
    for (int c = 0; c < 3; c++)
      res[c*8 +: 8] = 8'(mixCh(int'(es[c*8 +: 8]), int'(d[c*8 +: 8]), fsc, fdc));
    if (ken && kpos && res[23:0] == key) res = d;      // R10
    return res;
  endfunction

  task automatic drive(logic [31:0] s, logic [31:0] d, int a0, int a1, int sc, int dc,
      int sal, int dal, bit ken, bit kpos, logic [23:0] key, string tag);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1; srcPix = s; dstPix = d;
    alphaOp0 = 8'(a0); alphaOp1 = 8'(a1);
    srcColorSel = 3'(sc); dstColorSel = 3'(dc);
    srcAlphaSel = 2'(sal); dstAlphaSel = 2'(dal);
    keyEnable = ken; keyAfterBlend = kpos; keyColor = key;
    e.pix = model(s, d, a0, a1, sc, dc, sal, dal, ken, kpos, key);
    e.due = cyc + 2;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; srcPix = $urandom; dstPix = $urandom;
      srcColorSel = 3'($urandom); keyEnable = 1'b1; keyColor = srcPix[23:0];
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R1 unexpected outValid act=%h exp=none", outPix);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          checks++;
          if (cyc != e.due) begin
            failures++;
            $display("FAIL R1 latency act=%0d exp=%0d", cyc, e.due);
          end
          checks++;
          if (outPix !== e.pix) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", e.tag, outPix, e.pix);
          end
          lastOut = outPix;
          seenOut = 1;
        end
      end else if (seenOut) begin
        checks++;
        if (outPix !== lastOut) begin
          failures++;
          $display("FAIL R12 hold act=%h exp=%h", outPix, lastOut);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outPix !== 32'h0) begin
      failures++;
      $display("FAIL R12 reset act=%b/%h exp=0/00000000", outValid, outPix);
    end
    // R2 R3 plain copy and saturation
    drive(32'h80_10_20_30, 32'h40_50_60_70, 100, 200, 0, 0, 1, 0, 0, 0, 24'h0, "R2 copy");
    drive(32'hFF_FF_FF_FF, 32'hFF_FF_FF_FF, 0, 0, 0, 1, 1, 1, 0, 0, 24'h0, "R2 saturate");
    drive(32'hC8_FF_80_01, 32'hFF_FF_90_02, 0, 0, 0, 1, 1, 1, 0, 0, 24'h0, "R3 alpha saturate");
    // R4 every source colour code, incl reserved 6 and 7
    for (int c = 0; c < 8; c++)
      drive(32'h9A_C0_40_E1, 32'h33_12_F0_7F, 77, 201, c, 0, 2, 3, 0, 0, 24'h0, "R4 src colour code");
    // R5 every destination colour code
    for (int c = 0; c < 8; c++)
      drive(32'h6B_20_A0_FF, 32'hD3_80_10_44, 129, 17, 1, c, 3, 2, 0, 0, 24'h0, "R5 dst colour code");
    // R6 R7 every alpha code pair
    for (int c = 0; c < 16; c++)
      drive(32'h5E_11_22_33, 32'hB7_44_55_66, 181, 63, 2, 4, c % 4, c / 4, 0, 0, 24'h0, "R6 R7 alpha codes");
    // R8 rounding edge: 255-N and products near half
    drive(32'h01_80_80_80, 32'hFF_80_80_80, 128, 1, 4, 6, 2, 2, 0, 0, 24'h0, "R8 rounding");
    drive(32'h7F_01_02_03, 32'h81_FE_FD_FC, 255, 255, 3, 5, 3, 2, 0, 0, 24'h0, "R8 full operand");
    idle(3);
    // R9 pre-blend key hit: source alpha must come from destination
    drive(32'h10_AB_CD_EF, 32'hF0_01_02_03, 200, 50, 4, 6, 1, 2, 1, 0, 24'hABCDEF, "R9 pre key hit");
    drive(32'h10_AB_CD_EE, 32'hF0_01_02_03, 200, 50, 4, 6, 1, 2, 1, 0, 24'hABCDEF, "R9 pre key miss");
    // R10 post-blend key hit and source-only match
    drive(32'h22_AB_CD_EF, 32'h99_01_02_03, 10, 20, 0, 0, 1, 0, 1, 1, 24'hABCDEF, "R10 post key hit");
    drive(32'h22_AB_CD_EF, 32'h99_01_02_03, 10, 20, 2, 3, 1, 0, 1, 1, 24'hABCDEF, "R10 source match ignored");
    // R11 key disabled with matching pixel
    drive(32'h22_AB_CD_EF, 32'h99_01_02_03, 10, 20, 0, 0, 1, 0, 0, 0, 24'hABCDEF, "R11 key off pre");
    drive(32'h22_AB_CD_EF, 32'h99_01_02_03, 10, 20, 0, 0, 1, 0, 0, 1, 24'hABCDEF, "R11 key off post");
    idle(4);
    // R1 R2 mixed traffic with gaps
    for (int i = 0; i < 300; i++) begin
      logic [31:0] s, d;
      s = $urandom; d = $urandom;
      drive(s, d, int'($urandom_range(255)), int'($urandom_range(255)),
            int'($urandom_range(7)), int'($urandom_range(7)),
            int'($urandom_range(3)), int'($urandom_range(3)),
            bit'($urandom_range(1)), bit'($urandom_range(1)),
            ($urandom_range(1) == 1) ? s[23:0] : d[23:0], "R1 R2 mixed");
      if (i % 7 == 3) idle(int'($urandom_range(3)));
    end
    idle(6);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R1 missing results act=%0d exp=0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule